// File: doc/BRIEF.md
# Modulo address update unit

This unit computes the next value of a 32-bit address pointer for circular-buffer addressing. The pointer, a signed offset and a modifier word are presented together with an update mode. The unit returns the address to use for the memory access, the new pointer value, and a write-back strobe. The modifier word chooses the arithmetic. Plain 32-bit arithmetic ignores any buffer. Single-wrap modulo arithmetic works on a buffer of any length up to 2^24 words. Multiple-wrap modulo arithmetic works on power-of-two buffers and reduces offsets of any size exactly.

The arithmetic is combinational. A parameter can add one output register stage, and that stage is on by default. The register file that holds the pointers, instruction decoding and the memory port all sit outside the unit.

Top module: `mau_addr_unit`

## Requirements
- R1: Mode codes on `mode` have these meanings. 0 is post-increment by one. 1 is post-decrement by one. 2 is pre-decrement by one. 3 is post-add of the offset. 4 is post-subtract of the offset. 5 is indexed pointer+offset. In modes 0, 1, 3 and 4, the address is the old pointer, the updated pointer is the modified value, and the write strobe is 1. In mode 2, the address and the updated pointer are both the decremented value, and the write strobe is 1. In mode 5, the address is the modified pointer+offset, the updated pointer equals the input pointer, and the write strobe is 0. Codes 6 and 7 give address = updated pointer = input pointer with the write strobe at 0.
- R2: The modifier word selects the arithmetic. Upper byte 0x00 with a non-zero lower 24 bits selects single-wrap mode, with buffer size M = low24 + 1. Upper byte 0xFF with low24 = 2^k − 1 and 1 ≤ k ≤ 23 selects multiple-wrap mode, with M = 2^k. Every other word selects linear arithmetic, including 0x00000000, 0xFFFFFFFF and non-power-of-two masks under 0xFF.
- R3: In single-wrap mode, the base is the pointer with its low k bits cleared, where 2^k is the smallest power of two not below M. A step past base+M−1 wraps to the base. A step below the base wraps to base+M−1.
- R4: In single-wrap mode, with mode 3 or 4 and a positive offset that is a multiple of 2^k, the pointer moves by plain 32-bit addition or subtraction of the offset. This moves it by whole blocks.
- R5: In single-wrap mode, with an offset whose magnitude is at most M and that is not covered by R4, the result is base + ((pointer − base + step) mod M). Offsets larger than M that are not covered by R4 give an unspecified result.
- R6: In multiple-wrap mode, the result keeps the pointer bits at positions k and above. Its low k bits are the low k bits of pointer + step. This holds for any signed offset.
- R7: In linear mode, the result is pointer + step modulo 2^32.
- R8: With the output register enabled, the results appear one clock after the input is sampled. `out_valid` follows `in_valid` with that one-cycle delay. While reset is low at a clock edge, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request valid |
| mode | input | 3 | Update mode code (R1) |
| ptr | input | 32 | Current pointer value |
| ofs | input | 32 | Signed two's complement offset |
| mdf | input | 32 | Modifier word selecting the arithmetic (R2) |
| out_valid | output | 1 | Result valid |
| out_addr | output | 32 | Effective address for the access |
| out_ptr | output | 32 | Updated pointer value |
| out_ptr_we | output | 1 | Pointer write-back strobe |

## Verification
There is only one register between the inputs and the ports. An internal fault therefore shows up in the result one clock after the request that exercises it.

Each kind of fault shows up in its own way:
- A wrong block mask from the modifier decode moves the derived base. The pointer then lands in a different buffer, or wraps at the wrong boundary.
- A wrong wrap decision is visible only when the pointer is within one step of either boundary.
- A wrong offset sign shows in modes 4 and 5.

The reference model is compared on every clock. Its stimulus places pointers at the buffer edges, uses offsets that are exact block multiples, and uses offsets far larger than the buffer in the power-of-two case.

// File: rtl/mau_pkg.sv
// Shared types for the modulo address update unit.
package mau_pkg;

    // Update mode codes presented on the mode port.
    typedef enum logic [2:0] {
        MODE_POST_INC  = 3'd0,
        MODE_POST_DEC  = 3'd1,
        MODE_PRE_DEC   = 3'd2,
        MODE_POST_ADDN = 3'd3,
        MODE_POST_SUBN = 3'd4,
        MODE_INDEX     = 3'd5,
        MODE_RSVD6     = 3'd6,
        MODE_RSVD7     = 3'd7
    } mau_mode_e;

    // Arithmetic flavour decoded from the modifier word.
    typedef enum logic [1:0] {
        KIND_LINEAR = 2'd0,
        KIND_SINGLE = 2'd1,
        KIND_MULTI  = 2'd2
    } mau_kind_e;

endpackage

// File: rtl/mau_mod_decode.sv
// Modifier decode.
// Classifies the modifier word as linear, single-wrap or multiple-wrap.
// Produces the block mask that separates the base from the in-buffer offset.
// Assumes AW > MW. The upper AW-MW bits act as the mode tag.
module mau_mod_decode
    import mau_pkg::*;
#(
    parameter int AW = 32,
    parameter int MW = 24
) (
    input  logic [AW-1:0] mdf,
    output mau_kind_e     kind,
    output logic [AW-1:0] blk_mask,
    output logic [MW-1:0] m1
);
    localparam int TW = AW - MW;

    logic [TW-1:0] tag;
    logic [MW-1:0] low;
    logic [MW-1:0] fill;
    logic          is_single;
    logic          is_multi;

    assign tag = mdf[AW-1:MW];
    assign low = mdf[MW-1:0];
    assign m1  = low;

    // Smear the highest set bit of M-1 downwards to get the 2^k-1 block mask.
    always_comb begin
        logic acc;
        acc  = 1'b0;
        fill = '0;
        for (int i = MW - 1; i >= 0; i--) begin
            acc     = acc | low[i];
            fill[i] = acc;
        end
    end

    // Recognise the two modulo encodings; everything else falls back to linear.
    always_comb begin
        is_single = (tag == '0) && (low != '0);
        is_multi  = (tag == '1) && (low != '0) && !low[MW-1]
                    && ((low & (low + 1'b1)) == '0);
    end

    // Select the flavour and the mask that goes with it.
    always_comb begin
        if (is_single) begin
            kind     = KIND_SINGLE;
            blk_mask = {{TW{1'b0}}, fill};
        end else if (is_multi) begin
            kind     = KIND_MULTI;
            blk_mask = {{TW{1'b0}}, low};
        end else begin
            kind     = KIND_LINEAR;
            blk_mask = '0;
        end
    end

endmodule

// File: rtl/mau_offset_prep.sv
// Step preparation.
// Turns the mode and the offset into a signed step one bit wider than the pointer.
// Also flags the whole-block linear jump that applies to single-wrap mode.
// Assumes blk_mask is 2^k-1, or zero when no modulo mode is active.
module mau_offset_prep
    import mau_pkg::*;
#(
    parameter int AW = 32
) (
    input  mau_mode_e            mode,
    input  logic [AW-1:0]        ofs,
    input  logic [AW-1:0]        blk_mask,
    output logic signed [AW:0]   delta,
    output logic                 jump
);
    localparam int DW = AW + 1;

    logic signed [DW-1:0] ofs_ext;
    logic                 n_mode;

    assign ofs_ext = {ofs[AW-1], ofs};

    // Choose the signed step for each mode.
    always_comb begin
        unique case (mode)
            MODE_POST_INC:                 delta = DW'(1);
            MODE_POST_DEC, MODE_PRE_DEC:   delta = '1;
            MODE_POST_ADDN, MODE_INDEX:    delta = ofs_ext;
            MODE_POST_SUBN:                delta = -ofs_ext;
            default:                       delta = '0;
        endcase
    end

    // Positive offset that is a whole number of blocks, in an offset-modify mode.
    always_comb begin
        n_mode = (mode == MODE_POST_ADDN) || (mode == MODE_POST_SUBN);
        jump   = n_mode && !ofs[AW-1] && (ofs != '0) && ((ofs & blk_mask) == '0);
    end

endmodule

// File: rtl/mau_wrap_calc.sv
// Wrap arithmetic.
// Applies a signed step to the pointer under linear, single-wrap or multiple-wrap rules.
// The single-wrap path detects at most one wrap in either direction.
// Its result is defined only while |step| <= M and the pointer lies inside its buffer.
module mau_wrap_calc
    import mau_pkg::*;
#(
    parameter int AW = 32,
    parameter int MW = 24
) (
    input  logic [AW-1:0]      ptr,
    input  logic signed [AW:0] delta,
    input  logic               jump,
    input  mau_kind_e          kind,
    input  logic [AW-1:0]      blk_mask,
    input  logic [MW-1:0]      m1,
    output logic [AW-1:0]      res
);
    localparam int SW = AW + 2;

    logic [AW-1:0]        lin;
    logic [AW-1:0]        mres;
    logic [AW-1:0]        sres;
    logic [AW-1:0]        off;
    logic signed [SW-1:0] s_raw;
    logic signed [SW-1:0] s_fix;
    logic signed [SW-1:0] msz;

    // Plain two's complement sum, also the source of the low bits in multiple-wrap mode.
    assign lin  = ptr + delta[AW-1:0];
    assign mres = (ptr & ~blk_mask) | (lin & blk_mask);

    // In-buffer offset plus step, then a single correction by the buffer size.
    always_comb begin
        off   = ptr & blk_mask;
        msz   = SW'({1'b0, m1}) + SW'(1);
        s_raw = $signed({2'b00, off}) + $signed({delta[AW], delta});
        if (s_raw[SW-1])
            s_fix = s_raw + msz;
        else if (s_raw >= msz)
            s_fix = s_raw - msz;
        else
            s_fix = s_raw;
        sres = (ptr & ~blk_mask) | AW'(s_fix);
    end

    // Pick the result for the decoded flavour.
    always_comb begin
        unique case (kind)
            KIND_SINGLE: res = jump ? lin : sres;
            KIND_MULTI:  res = mres;
            default:     res = lin;
        endcase
    end

endmodule

// File: rtl/mau_addr_unit.sv
// Modulo address update unit, top level.
// Decodes the modifier, forms the step, and computes the wrapped value.
// Routes that value to the address and pointer outputs according to the mode.
// When OUT_REG is non-zero, one register stage with a synchronous
// active-low reset sits in front of the outputs.
// Data registers load only on valid requests.
module mau_addr_unit
    import mau_pkg::*;
#(
    parameter int AW      = 32,
    parameter int MW      = 24,
    parameter int OUT_REG = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    mode,
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] ofs,
    input  logic [AW-1:0] mdf,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic [AW-1:0] out_ptr,
    output logic          out_ptr_we
);
    mau_mode_e          mode_e;
    mau_kind_e          kind;
    logic [AW-1:0]      blk_mask;
    logic [MW-1:0]      m1;
    logic signed [AW:0] delta;
    logic               jump;
    logic [AW-1:0]      calc_res;
    logic [AW-1:0]      addr_c;
    logic [AW-1:0]      ptr_c;
    logic               we_c;
    logic               in_range;

    assign mode_e = mau_mode_e'(mode);

    mau_mod_decode #(.AW(AW), .MW(MW)) u_decode (
        .mdf      (mdf),
        .kind     (kind),
        .blk_mask (blk_mask),
        .m1       (m1)
    );

    mau_offset_prep #(.AW(AW)) u_prep (
        .mode     (mode_e),
        .ofs      (ofs),
        .blk_mask (blk_mask),
        .delta    (delta),
        .jump     (jump)
    );

    mau_wrap_calc #(.AW(AW), .MW(MW)) u_calc (
        .ptr      (ptr),
        .delta    (delta),
        .jump     (jump),
        .kind     (kind),
        .blk_mask (blk_mask),
        .m1       (m1),
        .res      (calc_res)
    );

    // Route the computed value to the address and pointer outputs according to the mode.
    always_comb begin
        unique case (mode_e)
            MODE_POST_INC, MODE_POST_DEC, MODE_POST_ADDN, MODE_POST_SUBN: begin
                addr_c = ptr;
                ptr_c  = calc_res;
                we_c   = 1'b1;
            end
            MODE_PRE_DEC: begin
                addr_c = calc_res;
                ptr_c  = calc_res;
                we_c   = 1'b1;
            end
            MODE_INDEX: begin
                addr_c = calc_res;
                ptr_c  = ptr;
                we_c   = 1'b0;
            end
            default: begin
                addr_c = ptr;
                ptr_c  = ptr;
                we_c   = 1'b0;
            end
        endcase
    end

    generate
        if (OUT_REG != 0) begin : g_reg
            // Output stage: valid follows the request; data loads on valid requests.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid  <= 1'b0;
                    out_addr   <= '0;
                    out_ptr    <= '0;
                    out_ptr_we <= 1'b0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) begin
                        out_addr   <= addr_c;
                        out_ptr    <= ptr_c;
                        out_ptr_we <= we_c;
                    end
                end
            end

            // R8: a request shows as valid exactly one clock later.
            p_valid_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            p_idle_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
        end else begin : g_comb
            assign out_valid  = in_valid;
            assign out_addr   = addr_c;
            assign out_ptr    = ptr_c;
            assign out_ptr_we = we_c;
        end
    endgenerate

    // Pointer lies inside its single-wrap buffer.
    assign in_range = (ptr & blk_mask) <= {{(AW-MW){1'b0}}, m1};

    // R6: multiple-wrap never changes the pointer bits above the block.
    p_multi_keeps_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == KIND_MULTI) |-> (((calc_res ^ ptr) & ~blk_mask) == '0));

    // R3: an upward unit step either advances by one or wraps to the base.
    p_unit_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == KIND_SINGLE && mode_e == MODE_POST_INC && in_range)
        |-> ((calc_res == ptr + 1'b1) || (calc_res == (ptr & ~blk_mask))));

    // R3: a downward unit step either retreats by one or wraps to base+M-1.
    p_unit_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == KIND_SINGLE && mode_e == MODE_POST_DEC && in_range)
        |-> ((calc_res == ptr - 1'b1)
             || (calc_res == ((ptr & ~blk_mask) | {{(AW-MW){1'b0}}, m1}))));

    // R3: a unit step keeps the result inside the same buffer.
    p_unit_in_buf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == KIND_SINGLE && in_range
         && (mode_e == MODE_POST_INC || mode_e == MODE_PRE_DEC))
        |-> (((calc_res & blk_mask) <= {{(AW-MW){1'b0}}, m1})
             && ((calc_res & ~blk_mask) == (ptr & ~blk_mask))));

endmodule

// File: tb/mau_addr_unit_tb.sv
`timescale 1ns/1ps
module mau_addr_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [31:0] ptr = '0;
    logic [31:0] ofs = '0;
    logic [31:0] mdf = '0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic [31:0] out_ptr;
    logic        out_ptr_we;

    int checks = 0;
    int fails = 0;

    typedef struct {
        bit          v;
        logic [31:0] a;
        logic [31:0] p;
        bit          we;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    mau_addr_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .mode       (mode),
        .ptr        (ptr),
        .ofs        (ofs),
        .mdf        (mdf),
        .out_valid  (out_valid),
        .out_addr   (out_addr),
        .out_ptr    (out_ptr),
        .out_ptr_we (out_ptr_we)
    );

    function automatic longint step_of(input logic [2:0] m, input logic [31:0] n);
        longint sn;
        sn = longint'($signed(n));
        case (m)
            3'd0:       return 1;
            3'd1, 3'd2: return -1;
            3'd3, 3'd5: return sn;
            3'd4:       return -sn;
            default:    return 0;
        endcase
    endfunction

    function automatic longint blk_of(input longint msize);
        longint b;
        b = 1;
        while (b < msize) b = b * 2;
        return b;
    endfunction

    // Reference rules from the requirements, written behaviourally.
    function automatic logic [31:0] ref_next(input logic [31:0] p, input logic [31:0] mn,
                                             input longint d, input bit nm,
                                             input logic [31:0] n);
        longint pl, msize, blk, base, s, sn;
        logic [31:0] mk, sm;
        bit multi;
        pl = longint'(p);
        sn = longint'($signed(n));
        multi = 1'b0;
        if (mn[31:24] == 8'h00 && mn[23:0] != 24'h0) begin
            msize = longint'(mn[23:0]) + 1;
            blk   = blk_of(msize);
            base  = pl - (pl % blk);
            if (nm && sn > 0 && (sn % blk) == 0) return 32'(pl + d);
            s = ((pl - base) + d) % msize;
            if (s < 0) s = s + msize;
            return 32'(base + s);
        end
        for (int k = 1; k <= 23; k++)
            if (mn[23:0] == 24'((1 << k) - 1)) multi = 1'b1;
        if (mn[31:24] == 8'hFF && multi) begin
            mk = {8'h00, mn[23:0]};
            sm = 32'(pl + d);
            return (p & ~mk) | (sm & mk);
        end
        return 32'(pl + d);
    endfunction

    task automatic check_pending();
        exp_t e;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        checks++;
        if (out_valid !== e.v ||
            (e.v && (out_addr !== e.a || out_ptr !== e.p || out_ptr_we !== e.we))) begin
            fails++;
            $display("FAIL %s: got v=%0b addr=%h ptr=%h we=%0b, expected v=%0b addr=%h ptr=%h we=%0b",
                     e.tag, out_valid, out_addr, out_ptr, out_ptr_we, e.v, e.a, e.p, e.we);
        end
    endtask

    // One request per clock: check the previous result, then drive the next request.
    task automatic drive(input logic [2:0] m, input logic [31:0] p, input logic [31:0] n,
                         input logic [31:0] mn, input bit v, input string tag);
        exp_t e;
        logic [31:0] r;
        @(negedge clk);
        check_pending();
        mode = m; ptr = p; ofs = n; mdf = mn; in_valid = v;
        r = ref_next(p, mn, step_of(m, n), (m == 3'd3 || m == 3'd4), n);
        e.v = v; e.tag = tag;
        case (m)
            3'd0, 3'd1, 3'd3, 3'd4: begin e.a = p; e.p = r; e.we = 1'b1; end
            3'd2:                   begin e.a = r; e.p = r; e.we = 1'b1; end
            3'd5:                   begin e.a = r; e.p = p; e.we = 1'b0; end
            default:                begin e.a = p; e.p = p; e.we = 1'b0; end
        endcase
        exp_q.push_back(e);
    endtask

    initial begin : wdog
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] p, n, mn;
        logic [23:0] low;
        longint msize, blk;
        string tag;
        // R8: outputs cleared while reset is low, even with a request present.
        in_valid = 1'b1; ptr = 32'h1234_5678; mdf = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_addr !== '0 || out_ptr !== '0 || out_ptr_we !== 1'b0) begin
            fails++;
            $display("FAIL R8 reset: got v=%0b addr=%h ptr=%h we=%0b, expected all zero",
                     out_valid, out_addr, out_ptr, out_ptr_we);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;

        // R3: wrap at both boundaries of a 32-word buffer based at 64.
        drive(3'd0, 32'd95, 32'd0, 32'h0000_001F, 1'b1, "R3 upper wrap");
        drive(3'd1, 32'd64, 32'd0, 32'h0000_001F, 1'b1, "R3 lower wrap");
        drive(3'd2, 32'd64, 32'd0, 32'h0000_001F, 1'b1, "R3 pre-dec wrap");
        // R3: non-power-of-two size 21 (block 32, base 32).
        drive(3'd0, 32'd52, 32'd0, 32'h0000_0014, 1'b1, "R3 M=21 upper wrap");
        drive(3'd1, 32'd32, 32'd0, 32'h0000_0014, 1'b1, "R3 M=21 lower wrap");
        // R5: offsets up to M.
        drive(3'd3, 32'd90, 32'd10, 32'h0000_001F, 1'b1, "R5 add wrap");
        drive(3'd4, 32'd66, 32'd10, 32'h0000_001F, 1'b1, "R5 sub wrap");
        drive(3'd3, 32'd40, 32'd21, 32'h0000_0014, 1'b1, "R5 add equal M");
        // R4: whole-block jumps.
        drive(3'd3, 32'd70, 32'd64, 32'h0000_001F, 1'b1, "R4 jump forward");
        drive(3'd4, 32'd70, 32'd32, 32'h0000_001F, 1'b1, "R4 jump back");
        // R6: large and negative offsets in multiple-wrap mode.
        drive(3'd3, 32'h1000_0045, 32'd1000, 32'hFF00_001F, 1'b1, "R6 large add");
        drive(3'd4, 32'h1000_0045, 32'h7FFF_FFFF, 32'hFF00_001F, 1'b1, "R6 max sub");
        drive(3'd5, 32'h1000_0045, 32'hFFFF_FC18, 32'hFF00_001F, 1'b1, "R6 negative index");
        // R7 and R2: linear and reserved modifier words.
        drive(3'd0, 32'hFFFF_FFFF, 32'd0, 32'hFFFF_FFFF, 1'b1, "R7 linear rollover");
        drive(3'd3, 32'd100, 32'd500, 32'hFF00_0005, 1'b1, "R2 reserved mask");
        drive(3'd3, 32'd100, 32'd500, 32'h1200_0010, 1'b1, "R2 reserved tag");
        drive(3'd1, 32'd0, 32'd0, 32'h0000_0000, 1'b1, "R2 zero modifier");
        // R1: index and reserved codes; R8: idle cycle.
        drive(3'd5, 32'd95, 32'd3, 32'h0000_001F, 1'b1, "R1 index no write");
        drive(3'd6, 32'd95, 32'd3, 32'h0000_001F, 1'b1, "R1 reserved code");
        drive(3'd7, 32'd10, 32'd3, 32'h0000_001F, 1'b1, "R1 reserved code");
        drive(3'd0, 32'd10, 32'd3, 32'h0000_001F, 1'b0, "R8 idle");

        for (int i = 0; i < 3000; i++) begin
            logic [2:0] m;
            int sel;
            m   = 3'($urandom_range(0, 7));
            sel = $urandom_range(0, 2);
            if (sel == 0) begin
                case ($urandom_range(0, 3))
                    0:       low = 24'($urandom_range(1, 40));
                    1:       low = 24'($urandom_range(1, 4096));
                    2:       low = 24'((1 << $urandom_range(1, 23)) - 1);
                    default: low = 24'($urandom);
                endcase
                if (low == 24'h0) low = 24'h1;
                mn    = {8'h00, low};
                msize = longint'(low) + 1;
                blk   = blk_of(msize);
                p     = $urandom;
                p     = 32'((longint'(p) - (longint'(p) % blk)) + (longint'($urandom) % msize));
                if ((m == 3'd3 || m == 3'd4) && $urandom_range(0, 3) == 0) begin
                    n   = 32'(blk * $urandom_range(1, 4));
                    tag = "R4 random";
                end else begin
                    n   = 32'(longint'($urandom_range(0, 32'(2 * msize))) - msize);
                    tag = (m <= 3'd2) ? "R3 random" : "R5 random";
                end
            end else if (sel == 1) begin
                mn  = {8'hFF, 24'((1 << $urandom_range(1, 23)) - 1)};
                p   = $urandom;
                n   = $urandom;
                tag = "R6 random";
            end else begin
                mn = $urandom;
                case ($urandom_range(0, 2))
                    0:       mn = 32'hFFFF_FFFF;
                    1:       if (mn[31:24] == 8'h00 || mn[31:24] == 8'hFF) mn[31:24] = 8'h5A;
                    default: mn = {8'hFF, mn[23:0] | 24'h5};
                endcase
                p   = $urandom;
                n   = $urandom;
                tag = "R7 random";
            end
            if (m >= 3'd5) tag = "R1 random";
            drive(m, p, n, mn, $urandom_range(0, 7) != 0, tag);
        end

        @(negedge clk);
        check_pending();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule